// File: doc/BRIEF.md
# Binary-Curve Point Membership Checker (GF(2^163))

This coprocessor decides whether an affine point (x, y) satisfies y^2 + x·y = x^3 + a·x^2 + b over GF(2^163). Field addition is bitwise XOR. Products are reduced by the pentanomial x^163 + x^7 + x^6 + x^3 + 1. The coefficients a and b are fixed when the block is built. The defaults are a = 1 and the 163-bit constant b of the standard pseudo-random curve. A Koblitz-style build sets b = 1 and a to 0 or 1.

Software first places the coordinates in a shared memory that is 32 bits wide and addressed by word. It then pulses the start input with the mode input high. The block reads the twelve operand words through a request/acknowledge port. It evaluates y·(x+y) and x^2·(x+a) + b with one multiplier that handles one bit per cycle. It writes a single verdict word back to the same memory and raises a completion flag.

Top module: `ec163_oncurve_check`

## Requirements
- R1: While the reset input is high, rd_req, wr_req and done are low. Reset acts at once, without waiting for a clock edge, and abandons any operation in progress.
- R2: When the block is idle and start is high with mode = 1 at a clock edge, the operation begins: done falls and rd_req rises in the next cycle with addr = 0.
- R3: A start sampled with mode = 0 is ignored, and so is a start sampled while an operation is in progress. Neither one changes the bus activity, the result or done.
- R4: Reads go to addresses 0 through 11 in increasing order, one at a time. x is in words 0–5 and y is in words 6–11, least significant word first. Each request holds rd_req and addr until ack is sampled high. Bits 31:3 of words 5 and 11 are ignored.
- R5: After the edge that acknowledges word 11, the block spends exactly 495 cycles with no memory request (three multiplications of 165 cycles each). In the following cycle wr_req rises with addr = 12.
- R6: The written word is 1 when y^2 + x·y equals x^3 + a·x^2 + b in GF(2^163), reduced by x^163 + x^7 + x^6 + x^3 + 1, and 0 otherwise. Bits 31:1 of the word are 0.
- R7: wr_req is held until ack. done rises at the edge that samples that ack and stays high until the next accepted start. No request is active while done is high.
- R8: rd_req and wr_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin request, sampled while idle |
| mode | input | 1 | 1 selects membership test; 0 is reserved and ignored |
| rd_req | output | 1 | Memory read request |
| wr_req | output | 1 | Memory write request |
| addr | output | AW (4) | Word address of the current request |
| wdata | output | DW (32) | Verdict word written to address 12 |
| rdata | input | DW (32) | Read data, taken in the cycle ack is high |
| ack | input | 1 | Completes the current read or write |
| done | output | 1 | Verdict has been written |

## Verification
A wrong fetch index or a lost word shows up as a bad address or a wrong read order within the first dozen requests. It can also show up as a verdict that disagrees with field arithmetic computed independently in the bench. A sequencer or multiplier counter that is off by one moves the write request away from its 495-cycle slot, and the per-clock comparison catches this in that same cycle. Faults in the reduction taps or the operand selection change the verdict on the generator point, on (0, √b), on (0, 0) and on a perturbed point. These faults are visible at the single write.

// File: rtl/ec163_pkg.sv
package ec163_pkg;

    localparam int FM = 163;
    localparam int CW = $clog2(FM);

    typedef logic [FM-1:0] fe_t;

    // low part of x^163 + x^7 + x^6 + x^3 + 1
    localparam fe_t RED_TAIL = 163'hC9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_GO,
        ST_WAIT,
        ST_STORE
    } ctl_st_e;

    // multiply a field element by x and fold the overflow bit back
    function automatic fe_t fe_xtime(fe_t v);
        return {v[FM-2:0], 1'b0} ^ (v[FM-1] ? RED_TAIL : '0);
    endfunction

endpackage

// File: rtl/gf163_bitser_mul.sv
module gf163_bitser_mul
    import ec163_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  fe_t  opa,
    input  fe_t  opb,
    output logic busy,
    output fe_t  prod
);

    typedef struct packed {
        fe_t           acc;
        fe_t           a;
        fe_t           b;
        logic [CW-1:0] cnt;
        logic          run;
    } mul_t;

    mul_t d, q;

    always_comb begin
        d = q;
        if (go) begin
            d.acc = '0;
            d.a   = opa;
            d.b   = opb;
            d.cnt = CW'(FM - 1);
            d.run = 1'b1;
        end else if (q.run) begin
            d.acc = fe_xtime(q.acc) ^ (q.b[FM-1] ? q.a : '0);
            d.b   = {q.b[FM-2:0], 1'b0};
            if (q.cnt == '0) begin
                d.run = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.run;
    assign prod = q.acc;

    AST_MUL_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        go |=> busy); // R5
    AST_MUL_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy); // R5

endmodule

// File: rtl/ec163_oncurve_check.sv
module ec163_oncurve_check
    import ec163_pkg::*;
#(
    parameter int          DW      = 32,
    parameter int          AW      = 4,
    parameter logic        A_COEF  = 1'b1,
    parameter logic [162:0] B_CONST = 163'h2_0A601907_B8C953CA_1481EB10_512F7874_4A3205FD
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode,
    output logic          rd_req,
    output logic          wr_req,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    input  logic [DW-1:0] rdata,
    input  logic          ack,
    output logic          done
);

    localparam int            NW       = (FM + DW - 1) / DW;
    localparam logic [AW-1:0] HALF     = AW'(NW);
    localparam logic [AW-1:0] LAST_RD  = AW'(2 * NW - 1);
    localparam logic [AW-1:0] RES_ADDR = AW'(2 * NW);
    localparam fe_t           A_FE     = {{(FM-1){1'b0}}, A_COEF};

    typedef struct packed {
        ctl_st_e       st;
        logic [AW-1:0] widx;
        fe_t           x;
        fe_t           y;
        logic [1:0]    phase;
        fe_t           lhs;
        fe_t           sq;
        logic          verdict;
        logic          done;
    } ctl_t;

    ctl_t d, q;

    logic mul_go;
    logic mul_busy;
    fe_t  mul_a;
    fe_t  mul_b;
    fe_t  mul_p;

    // drop one bus word into its slot; bits above FM fall away
    function automatic fe_t put_word(fe_t v, logic [AW-1:0] k, logic [DW-1:0] w);
        logic [NW*DW-1:0] t;
        t          = '0;
        t[FM-1:0]  = v;
        t[int'(k)*DW +: DW] = w;
        return t[FM-1:0];
    endfunction

    always_comb begin
        case (q.phase)
            2'd0: begin
                mul_a = q.y;
                mul_b = q.x ^ q.y;
            end
            2'd1: begin
                mul_a = q.x;
                mul_b = q.x;
            end
            default: begin
                mul_a = q.sq;
                mul_b = q.x ^ A_FE;
            end
        endcase
    end

    always_comb begin
        d      = q;
        mul_go = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start && mode) begin
                    d.st    = ST_FETCH;
                    d.widx  = '0;
                    d.phase = 2'd0;
                    d.done  = 1'b0;
                end
            end
            ST_FETCH: begin
                if (ack) begin
                    if (q.widx < HALF) begin
                        d.x = put_word(q.x, q.widx, rdata);
                    end else begin
                        d.y = put_word(q.y, q.widx - HALF, rdata);
                    end
                    if (q.widx == LAST_RD) begin
                        d.st = ST_GO;
                    end else begin
                        d.widx = q.widx + 1'b1;
                    end
                end
            end
            ST_GO: begin
                mul_go = 1'b1;
                d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (!mul_busy) begin
                    case (q.phase)
                        2'd0: begin
                            d.lhs   = mul_p;
                            d.phase = 2'd1;
                            d.st    = ST_GO;
                        end
                        2'd1: begin
                            d.sq    = mul_p;
                            d.phase = 2'd2;
                            d.st    = ST_GO;
                        end
                        default: begin
                            d.verdict = ((mul_p ^ B_CONST) == q.lhs);
                            d.st      = ST_STORE;
                        end
                    endcase
                end
            end
            ST_STORE: begin
                if (ack) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= '{st: ST_IDLE, phase: 2'd0, default: '0};
        end else begin
            q <= d;
        end
    end

    gf163_bitser_mul u_mul (
        .clk  (clk),
        .rst  (rst),
        .go   (mul_go),
        .opa  (mul_a),
        .opb  (mul_b),
        .busy (mul_busy),
        .prod (mul_p)
    );

    assign rd_req = (q.st == ST_FETCH);
    assign wr_req = (q.st == ST_STORE);
    assign addr   = wr_req ? RES_ADDR : q.widx;
    assign wdata  = {{(DW-1){1'b0}}, q.verdict};
    assign done   = q.done;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req)); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req && !ack |=> rd_req && $stable(addr)); // R4
    AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> addr < RES_ADDR); // R4
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_req && !ack |=> wr_req && $stable(wdata)); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req && !wr_req); // R7
    AST_WR_DONE: assert property (@(posedge clk) disable iff (rst)
        wr_req && ack |=> done); // R7
    AST_VERDICT_BIT: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> wdata[DW-1:1] == '0); // R6

endmodule

// File: tb/ec163_oncurve_check_test.sv
`timescale 1ns/1ps
module ec163_oncurve_check_test;

    localparam logic [162:0] BC = 163'h2_0A601907_B8C953CA_1481EB10_512F7874_4A3205FD;
    localparam logic [162:0] GX = 163'h3_F0EBA162_86A2D57E_A0991168_D4994637_E8343E36;
    localparam logic [162:0] GY = 163'h0_D51FBC6C_71A0094F_A2CDD545_B11C5C0C_797324F1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic        rd_req, wr_req, done;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata = '0;
    logic        ack = 1'b0;

    logic [31:0] mem [0:15];
    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit chk_en = 0;

    // reference model state
    int   m_st = 0;
    int   m_idx = 0;
    int   m_cnt = 0;
    bit   m_done = 0;
    bit   m_res = 0;
    int   lat = 0;
    int   seq = 0;

    always #2.5 clk = ~clk;

    ec163_oncurve_check uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .rd_req(rd_req), .wr_req(wr_req), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack(ack), .done(done)
    );

    function automatic logic [162:0] f_mul(logic [162:0] a, logic [162:0] b);
        logic [324:0] p = '0;
        for (int i = 0; i < 163; i++) if (b[i]) p ^= 325'(a) << i;
        for (int i = 324; i >= 163; i--)
            if (p[i]) p ^= 325'({1'b1, 163'hC9}) << (i - 163);
        return p[162:0];
    endfunction

    function automatic bit f_oncurve(logic [162:0] x, logic [162:0] y);
        logic [162:0] x2 = f_mul(x, x);
        return (f_mul(y, y) ^ f_mul(x, y)) == (f_mul(x2, x) ^ x2 ^ BC);
    endfunction

    function automatic bit mem_oncurve();
        logic [191:0] xw, yw;
        for (int i = 0; i < 6; i++) begin
            xw[32*i +: 32] = mem[i];
            yw[32*i +: 32] = mem[6+i];
        end
        return f_oncurve(xw[162:0], yw[162:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each edge
    always @(posedge clk or posedge rst) begin
        cyc++;
        if (rst) begin
            m_st = 0; m_idx = 0; m_done = 0;
        end else begin
            case (m_st)
                0: if (start && mode) begin m_st = 1; m_idx = 0; m_done = 0; end
                1: if (ack) begin
                       if (m_idx == 11) begin m_st = 2; m_cnt = 495; m_res = mem_oncurve(); end
                       else m_idx++;
                   end
                2: begin m_cnt--; if (m_cnt == 0) m_st = 3; end
                default: if (ack) begin m_st = 0; m_done = 1; end
            endcase
        end
    end

    // compare on every clock, then act as memory
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            chk(rd_req == (m_st == 1), "R4 rd_req", 64'(rd_req), 64'(m_st == 1));
            chk(wr_req == (m_st == 3), "R5 wr_req", 64'(wr_req), 64'(m_st == 3));
            chk(done == m_done, "R7 done", 64'(done), 64'(m_done));
            if (m_st == 1) chk(addr == 4'(m_idx), "R4 addr", 64'(addr), 64'(m_idx));
            if (m_st == 3) begin
                chk(addr == 4'd12, "R5 addr", 64'(addr), 64'd12);
                chk(wdata == {31'b0, m_res}, "R6 wdata", 64'(wdata), 64'(m_res));
            end
            chk(!(rd_req && wr_req), "R8 exclusive", 64'({rd_req, wr_req}), 64'd0);
        end
        if (rst) begin
            ack = 0; lat = 0;
        end else if (ack) begin
            ack = 0;
        end else if (rd_req || wr_req) begin
            if (lat == 0) begin
                ack = 1;
                if (rd_req) rdata = mem[addr];
                else mem[addr] = wdata;
                seq++;
                lat = (seq * 5 + 1) % 4;
            end else begin
                lat--;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic load_pt(input logic [162:0] x, input logic [162:0] y, input bit junk);
        logic [191:0] xw = 192'(x);
        logic [191:0] yw = 192'(y);
        for (int i = 0; i < 6; i++) begin
            mem[i]   = xw[32*i +: 32];
            mem[6+i] = yw[32*i +: 32];
        end
        if (junk) begin
            mem[5]  |= 32'hFFFF_FFF8;
            mem[11] |= 32'hA5A5_A5A8;
        end
        mem[12] = 32'hDEAD_BEEF;
    endtask

    task automatic pulse(input bit md);
        @(negedge clk);
        start = 1; mode = md;
        @(negedge clk);
        start = 0; mode = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input logic [162:0] x, input logic [162:0] y, input bit junk,
                            input bit expv, input string tag);
        load_pt(x, y, junk);
        pulse(1);
        wait_done();
        chk(done == 1'b1, "R7 done after run", 64'(done), 64'd1);
        chk(mem[12] == {31'b0, expv}, tag, 64'(mem[12]), 64'(expv));
    endtask

    initial begin
        logic [162:0] sb;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        sb = BC;
        for (int i = 0; i < 162; i++) sb = f_mul(sb, sb);

        repeat (3) @(negedge clk);
        chk(!rd_req && !wr_req && !done, "R1 reset outputs", 64'({rd_req, wr_req, done}), 64'd0);
        #1 rst = 0;
        chk_en = 1;
        repeat (3) @(negedge clk);

        // R6: generator point, per bench arithmetic
        run_case(GX, GY, 0, f_oncurve(GX, GY), "R6 generator");
        // R6: (0, sqrt b) is always on the curve
        run_case('0, sb, 0, 1'b1, "R6 zero-x point");
        // R6: one flipped bit in y takes the point off the curve
        run_case(GX, GY ^ 163'h10, 0, 1'b0, "R6 perturbed point");
        // R6: origin gives b on the right, 0 on the left
        run_case('0, '0, 0, 1'b0, "R6 origin");
        // R4: garbage above bit 162 is ignored
        run_case('0, sb, 1, 1'b1, "R4 upper bits ignored");

        // R7: done holds while idle
        repeat (30) @(negedge clk);
        chk(done == 1'b1, "R7 done held", 64'(done), 64'd1);

        // R3: mode low is ignored
        mem[12] = 32'h5555_5555;
        pulse(0);
        repeat (20) @(negedge clk);
        chk(done == 1'b1 && !rd_req, "R3 mode low ignored", 64'({done, rd_req}), 64'h2);
        chk(mem[12] == 32'h5555_5555, "R3 no write on mode low", 64'(mem[12]), 64'h5555_5555);

        // R2 and R3: accepted start, then a start while busy
        load_pt(GX, GY ^ 163'h10, 0);
        pulse(1);
        chk(!done && rd_req && addr == 0, "R2 start accepted", 64'({done, rd_req, addr}), 64'h10);
        repeat (100) @(negedge clk);
        pulse(1);
        wait_done();
        chk(mem[12] == 32'd0, "R3 busy start ignored", 64'(mem[12]), 64'd0);
        repeat (5) @(negedge clk);
        chk(!rd_req && !wr_req, "R3 no restart", 64'({rd_req, wr_req}), 64'd0);

        // R1: asynchronous reset mid-fetch
        load_pt(GX, GY, 0);
        pulse(1);
        repeat (4) @(negedge clk);
        #1 rst = 1;
        #0.5;
        chk(!rd_req && !wr_req && !done, "R1 async reset", 64'({rd_req, wr_req, done}), 64'd0);
        @(negedge clk);
        #1 rst = 0;
        repeat (3) @(negedge clk);
        run_case(GX, GY, 0, f_oncurve(GX, GY), "R6 after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule